// File: doc/BRIEF.md
# Prioritised Pending Interrupt Arbiter

This block collects asynchronous interrupt requests from external pins and timers, one register bit per source. When the core asks for an evaluation, the block finds the single most urgent request that the current machine-state enable bits allow. It then reports that request to the exception entry logic as a one-cycle take strobe with a cause code. Requests are ranked in three tiers. The first tier is never masked. The second tier depends on the critical enable. The third tier depends on the external enable.

A source is either pulse-type or level-type. A pulse-type source is latched when its set pulse arrives and is cleared when it is taken. A level-type source (the critical external input and the external input) follows its request line. Taking it does not clear it, so the requester must drop the line once it has been serviced. Vectoring and the saving of state belong to the logic downstream.

Top module: `irq_arbiter`

## Requirements
- R1: A pending system reset request (cause 0) wins every evaluation. A pending machine check (cause 1) wins when no reset is pending. Neither is masked by any enable input.
- R2: The hypervisor decrementer (cause 2) is eligible only when `hdec_en_i` is 1 and at least one of these holds: `ee_i` = 1, `hv_i` = 0, or `pr_i` = 1.
- R3: The critical external request (cause 3, level-type) is eligible only while `ce_i` = 1. Taking it leaves it pending for as long as `set_i[3]` stays high, and it drops the cycle after the line falls.
- R4: With `ee_i` = 1, the remaining sources rank as follows, from highest to lowest: watchdog (4), critical doorbell (5), fixed-interval timer (6), programmable interval timer (7), decrementer (8), external input (9), doorbell (10), performance monitor (11), thermal (12). With `ee_i` = 0, none of causes 4 to 12 is eligible.
- R5: The external input (cause 9) is level-type. Taking it leaves it pending, so while its line stays high it blocks causes 10 to 12 at every evaluation.
- R6: An evaluation is requested by holding `eval_i` high for one clock. In the following cycle, `take_o` is high for exactly that cycle and `cause_o` carries the index of the highest-ranked eligible source. The cause code equals the bit position in `set_i`.
- R7: Taking a pulse-type source clears its pending bit. If a set pulse for the same bit arrives in the same cycle as the clear, the bit stays set.
- R8: When no source is eligible, an evaluation produces no take strobe.
- R9: A pulse-type request that is masked stays pending, and it is taken at the first evaluation after its enable condition is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| set_i | input | 13 | Set pulses (pulse-type bits) or request levels (bits 3 and 9) |
| eval_i | input | 1 | Evaluation request |
| ee_i | input | 1 | External interrupt enable |
| ce_i | input | 1 | Critical interrupt enable |
| hv_i | input | 1 | Hypervisor state |
| pr_i | input | 1 | Problem (user) state |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| take_o | output | 1 | One-cycle strobe: an interrupt is issued |
| cause_o | output | 4 | Index of the issued source |

## Verification
The only internal state is the pending vector, and it can be observed only through later evaluations. A bit that is wrongly lost shows up as a missing take at the next evaluation that should have selected it. A bit that is wrongly kept, such as a pulse source that survives being taken or a level source that outlives its line, shows up as a repeated cause at the next evaluation, one cycle after the strobe. The tests therefore follow each take with a further evaluation. They also hold masked requests across several evaluations, so that a dropped or sticky bit becomes visible within two clocks.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int IRQ_NUM = 13;

   // Bit positions double as cause codes; lower index means higher rank.
   localparam int SRC_RST   = 0;
   localparam int SRC_MCK   = 1;
   localparam int SRC_HDEC  = 2;
   localparam int SRC_CRIT  = 3;
   localparam int SRC_EE_LO = 4;   // first source gated by the external enable
   localparam int SRC_EXT   = 9;

   localparam logic [IRQ_NUM-1:0] LEVEL_DEFAULT =
      IRQ_NUM'((1 << SRC_CRIT) | (1 << SRC_EXT));
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int          N          = 13,
   parameter logic [N-1:0] LEVEL_MASK = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar k = 0; k < N; k++) begin : g_bit
      if (LEVEL_MASK[k]) begin : g_level
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pend_o[k] <= 1'b0;
            else         pend_o[k] <= set_i[k];
         end
      end else begin : g_pulse
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pend_o[k] <= 1'b0;
            else         pend_o[k] <= set_i[k] | (pend_o[k] & ~clr_i[k]);
         end
      end
   end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
   import irq_arb_pkg::*;
(
   input  logic [IRQ_NUM-1:0] pend_i,
   input  logic               ee_i,
   input  logic               ce_i,
   input  logic               hv_i,
   input  logic               pr_i,
   input  logic               hdec_en_i,
   output logic [IRQ_NUM-1:0] elig_o
);
   logic hdec_ok;

   always_comb begin
      hdec_ok = hdec_en_i & (ee_i | ~hv_i | pr_i);
      elig_o  = '0;
      elig_o[SRC_RST]  = pend_i[SRC_RST];
      elig_o[SRC_MCK]  = pend_i[SRC_MCK];
      elig_o[SRC_HDEC] = pend_i[SRC_HDEC] & hdec_ok;
      elig_o[SRC_CRIT] = pend_i[SRC_CRIT] & ce_i;
      for (int k = SRC_EE_LO; k < IRQ_NUM; k++) begin
         elig_o[k] = pend_i[k] & ee_i;
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N = 13,
   parameter int W = 4
) (
   input  logic [N-1:0] req_i,
   output logic         any_o,
   output logic [W-1:0] idx_o,
   output logic [N-1:0] onehot_o
);
   always_comb begin
      any_o    = |req_i;
      idx_o    = '0;
      onehot_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            idx_o    = W'(k);
            onehot_o = N'(1) << k;
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int                  CAUSE_W    = 4,
   parameter logic [IRQ_NUM-1:0] LEVEL_MASK = LEVEL_DEFAULT
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [IRQ_NUM-1:0] set_i,
   input  logic               eval_i,
   input  logic               ee_i,
   input  logic               ce_i,
   input  logic               hv_i,
   input  logic               pr_i,
   input  logic               hdec_en_i,
   output logic               take_o,
   output logic [CAUSE_W-1:0] cause_o
);
   localparam int MIN_W = $clog2(IRQ_NUM);

   if (CAUSE_W < MIN_W) begin : g_bad_width
      $error("irq_arbiter: CAUSE_W too narrow for the source count");
   end

   logic [IRQ_NUM-1:0] pend_q;
   logic [IRQ_NUM-1:0] elig;
   logic [IRQ_NUM-1:0] win_oh;
   logic [IRQ_NUM-1:0] clr;
   logic               any_elig;
   logic [CAUSE_W-1:0] win_idx;

   irq_pending #(.N(IRQ_NUM), .LEVEL_MASK(LEVEL_MASK)) u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i),
      .clr_i  (clr),
      .pend_o (pend_q)
   );

   irq_gate u_gate (
      .pend_i    (pend_q),
      .ee_i      (ee_i),
      .ce_i      (ce_i),
      .hv_i      (hv_i),
      .pr_i      (pr_i),
      .hdec_en_i (hdec_en_i),
      .elig_o    (elig)
   );

   irq_pick #(.N(IRQ_NUM), .W(CAUSE_W)) u_pick (
      .req_i    (elig),
      .any_o    (any_elig),
      .idx_o    (win_idx),
      .onehot_o (win_oh)
   );

   // Only the winner of a real evaluation is retired; level sources never are.
   assign clr = (eval_i && any_elig) ? (win_oh & ~LEVEL_MASK) : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         take_o  <= 1'b0;
         cause_o <= '0;
      end else begin
         take_o <= eval_i & any_elig;
         if (eval_i && any_elig) cause_o <= win_idx;
      end
   end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
   import irq_arb_pkg::*;
#(
   parameter int CAUSE_W = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               eval_i,
   input logic               ee_i,
   input logic               ce_i,
   input logic [IRQ_NUM-1:0] pend_q,
   input logic [IRQ_NUM-1:0] elig,
   input logic               take_o,
   input logic [CAUSE_W-1:0] cause_o
);
   assert_take_after_eval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> $past(eval_i));

   assert_reset_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && pend_q[SRC_RST]) |=> (take_o && cause_o == CAUSE_W'(SRC_RST)));

   assert_mck_second_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && !pend_q[SRC_RST] && pend_q[SRC_MCK]) |=>
      (take_o && cause_o == CAUSE_W'(SRC_MCK)));

   assert_idle_eval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && elig == '0) |=> !take_o);

   assert_crit_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && cause_o == CAUSE_W'(SRC_CRIT)) |-> $past(ce_i));

   assert_ext_tier_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && cause_o >= CAUSE_W'(SRC_EE_LO)) |-> $past(ee_i));
endmodule

bind irq_arbiter irq_arbiter_chk #(.CAUSE_W(CAUSE_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .eval_i  (eval_i),
   .ee_i    (ee_i),
   .ce_i    (ce_i),
   .pend_q  (pend_q),
   .elig    (elig),
   .take_o  (take_o),
   .cause_o (cause_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
   localparam int N = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pulse_r = '0;
   logic [N-1:0]  lvl_r = '0;
   logic [N-1:0]  set_w;
   logic          eval = 1'b0;
   logic          ee = 1'b0, ce = 1'b0, hv = 1'b1, pr = 1'b0, hden = 1'b0;
   logic          take;
   logic [3:0]    cause;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   assign set_w = pulse_r | lvl_r;

   always #2.5 clk = ~clk;

   irq_arbiter u0 (
      .clk_i (clk), .rst_ni (rst_n), .set_i (set_w), .eval_i (eval),
      .ee_i (ee), .ce_i (ce), .hv_i (hv), .pr_i (pr), .hdec_en_i (hden),
      .take_o (take), .cause_o (cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [N-1:0] m);
      @(negedge clk); pulse_r = m;
      @(negedge clk); pulse_r = '0;
   endtask

   // exp_cause < 0 means no take expected
   task automatic evaluate(input string req, input int exp_cause,
                           input logic [N-1:0] extra = '0);
      @(negedge clk); eval = 1'b1; pulse_r = extra;
      @(negedge clk); eval = 1'b0; pulse_r = '0;
      if (exp_cause < 0) chk(req, int'(take), 0);
      else begin
         chk(req, int'(take), 1);
         chk(req, int'(cause), exp_cause);
      end
      @(negedge clk);
      chk({req, " strobe one cycle R6"}, int'(take), 0);
   endtask

   task automatic t_reset_state;
      chk("R6 take after reset", int'(take), 0);
      chk("R6 cause after reset", int'(cause), 0);
      evaluate("R8 empty", -1);
   endtask

   task automatic t_untiered;
      ee = 0; ce = 0; hden = 0;
      pulse(13'h1003);                    // reset, machine check, thermal
      evaluate("R1 reset first", 0);
      evaluate("R1 mcheck second", 1);
      evaluate("R9 thermal masked", -1);
      evaluate("R9 thermal still masked", -1);
      ee = 1;
      evaluate("R9 thermal after enable", 12);
      evaluate("R7 thermal cleared", -1);
      ee = 0;
   endtask

   task automatic t_hdec;
      pulse(13'h0004);
      hden = 0; ee = 1; hv = 0; pr = 1;
      evaluate("R2 enable off", -1);
      hden = 1; ee = 0; hv = 1; pr = 0;
      evaluate("R2 no condition", -1);
      hv = 0;
      evaluate("R2 hv clear", 2);
      pulse(13'h0004); hv = 1; pr = 1;
      evaluate("R2 problem state", 2);
      pulse(13'h0004); pr = 0; ee = 1;
      evaluate("R2 ee set", 2);
      evaluate("R7 hdec cleared", -1);
      hden = 0; ee = 0;
   endtask

   task automatic t_crit;
      lvl_r[3] = 1'b1; ce = 0;
      evaluate("R3 ce off", -1);
      ce = 1;
      evaluate("R3 crit taken", 3);
      evaluate("R3 crit stays", 3);
      lvl_r[3] = 1'b0;
      evaluate("R3 crit dropped", -1);
      ce = 0;
   endtask

   task automatic t_order;
      ee = 1;
      lvl_r[9] = 1'b1;
      pulse(13'h1DF0);
      for (int c = 4; c <= 9; c++) evaluate("R4 order", c);
      evaluate("R5 ext stays and blocks", 9);
      lvl_r[9] = 1'b0;
      for (int c = 10; c <= 12; c++) evaluate("R4 order low", c);
      evaluate("R7 all cleared", -1);
      ee = 0;
   endtask

   task automatic t_cross_tier;
      ee = 1; ce = 1; lvl_r[3] = 1'b1;
      pulse(13'h0012);                    // machine check + watchdog
      evaluate("R6 mcheck over crit", 1);
      evaluate("R6 crit over watchdog", 3);
      lvl_r[3] = 1'b0;
      evaluate("R6 watchdog last", 4);
      evaluate("R8 nothing left", -1);
      ee = 0; ce = 0;
   endtask

   task automatic t_set_wins;
      ee = 1;
      pulse(13'h0100);
      evaluate("R7 take with same-cycle set", 8, 13'h0100);
      evaluate("R7 set won over clear", 8);
      evaluate("R7 cleared afterwards", -1);
      ee = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_untiered();
      t_hdec();
      t_crit();
      t_order();
      t_cross_tier();
      t_set_wins();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule